// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block counts rising edges of a slow count input and presents the count as ten one-hot decoded outputs plus a carry that is high for the first half of every ten-count cycle. The count is held in a five-bit twisted-ring (Johnson) register. Exactly one bit of that register changes per step, and each decoded output looks at only two neighbouring bits, so the decoded outputs step cleanly from one to the next.

The count pin and an active-high inhibit pin are oversampled by a faster system clock through two-flop synchronizers. The block advances on each 0-to-1 transition of (count AND NOT inhibit). So a count rise with inhibit low advances it, and so does inhibit falling while count is high. The clear input forces count 0 asynchronously and is released on the system clock. Feeding decoded output n back into clear shortens the cycle to n counts. A corrupted ring pattern is folded back to count 0 on the next system clock.

Top module: `johnson_decade_div`

## Requirements
- R1: After clear is released, `dec_o` is 10'b00_0000_0001 (bit 0 = count 0) and `carry_o` is 1.
- R2: Outside clear, exactly one bit of `dec_o` is high at every system clock edge.
- R3: Each advance moves the count from k to (k+1) mod 10; bit k of `dec_o` is high at count k.
- R4: While `inhibit_i` is high, edges on `count_i` leave `dec_o` unchanged.
- R5: A falling `inhibit_i` while `count_i` is high advances the count by exactly one; a falling `count_i` never advances it.
- R6: `carry_o` is 1 for counts 0 to 4 and 0 for counts 5 to 9.
- R7: With default parameters, `dec_o` is unchanged two system clock rising edges after the gated count input rises, and shows the new count after the third.
- R8: Raising `clear_i` forces `dec_o` to count 0 and `carry_o` to 1 without waiting for a system clock edge; count 0 holds after release until the next real advance.
- R9: A `count_i` rise that happens while clear is held causes no advance when clear is released.
- R10: With `dec_o[n]` fed back into `clear_i`, the count cycles through 0 to n-1, and bit n is never seen high at a sampling point.
- R11: An illegal ring pattern (more than one transition between neighbouring bits) returns to count 0 on the next system clock edge.
- R12: `count_i` rising in the same system cycle as `inhibit_i` rises causes no advance, and both falling together causes none either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the pins |
| count_i | input | 1 | Count input, advances on its rising edge |
| inhibit_i | input | 1 | High blocks counting; its fall while count is high advances |
| clear_i | input | 1 | Active-high clear, asserted asynchronously |
| dec_o | output | 10 | One-hot decoded count, bit k high at count k |
| carry_o | output | 1 | High for counts 0 to 4 |

## Verification
The two functions that meet in one cycle are gating and edge detection: a change on `count_i` and a change on `inhibit_i` can reach the gate in the same sampled cycle. The bench drives both pins on the same clock low phase, first both rising and then both falling. It judges the result by the decoded outputs staying at the previous count, and by the next clean count pulse still advancing by one. A second case lets a decoded output clear the counter in the cycle it was reached; there the checked result is the length of the count sequence.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  // Shortest chain that still resolves metastability on the pins.
  localparam int unsigned JDC_MIN_SYNC = 2;

  // Pin pair carried through the synchronizer together so both see equal delay.
  typedef struct packed {
    logic pulse;
    logic inhibit;
  } jdc_pins_t;
endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  // Reset-less chain: a clear must not create a fake edge at release.
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) stage_q[0] <= din;
      end else begin : g_rest
        always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/jdc_clr_sync.sv
module jdc_clr_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic clr_async,
  output logic clr_hold
);
  logic [DEPTH-1:0] hold_q;

  // Asserts the moment the pin rises, lets go on the system clock.
  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async) hold_q <= '1;
    else           hold_q <= {hold_q[DEPTH-2:0], 1'b0};
  end

  assign clr_hold = hold_q[DEPTH-1];
endmodule

// File: rtl/jdc_advance.sv
module jdc_advance
  import jdc_pkg::*;
(
  input  logic      clk,
  input  jdc_pins_t pins,
  output logic      adv
);
  logic gated;
  logic gated_prev_q;

  assign gated = pins.pulse & ~pins.inhibit;

  // History always follows the gate, so a rise during clear is absorbed.
  always_ff @(posedge clk) gated_prev_q <= gated;

  assign adv = gated & ~gated_prev_q;
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring #(
  parameter int unsigned STAGES = 5
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              adv,
  output logic [STAGES-1:0] ring_q,
  output logic [STAGES-1:0] ring_nxt
);
  logic [STAGES-2:0] edges;
  logic              legal;

  // A valid twisted-ring word has at most one neighbour transition.
  assign edges = ring_q[STAGES-2:0] ^ ring_q[STAGES-1:1];
  assign legal = ($countones(edges) <= 1);

  always_comb begin
    if (!legal)   ring_nxt = '0;
    else if (adv) ring_nxt = {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
    else          ring_nxt = ring_q;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) ring_q <= '0;
    else     ring_q <= ring_nxt;
  end
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned COUNT = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  output logic [COUNT-1:0]  dec,
  output logic              carry
);
  // Each count is recognised from one pair of neighbouring ring bits.
  generate
    for (genvar k = 0; k < COUNT; k++) begin : g_dec
      if (k == 0) begin : g_zero
        assign dec[k] = ~ring[0] & ~ring[STAGES-1];
      end else if (k < STAGES) begin : g_fill
        assign dec[k] = ring[k-1] & ~ring[k];
      end else if (k == STAGES) begin : g_full
        assign dec[k] = ring[STAGES-1] & ring[0];
      end else begin : g_drain
        assign dec[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
      end
    end
  endgenerate

  assign carry = ~ring[STAGES-1];
endmodule

// File: rtl/johnson_decade_div.sv
module johnson_decade_div
  import jdc_pkg::*;
#(
  parameter int unsigned STAGES      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLR_STAGES  = 2,
  localparam int unsigned COUNT      = 2 * STAGES
) (
  input  logic             clk,
  input  logic             count_i,
  input  logic             inhibit_i,
  input  logic             clear_i,
  output logic [COUNT-1:0] dec_o,
  output logic             carry_o
);
  localparam int unsigned SYNC_D = (SYNC_STAGES < JDC_MIN_SYNC) ? JDC_MIN_SYNC : SYNC_STAGES;
  localparam int unsigned CLR_D  = (CLR_STAGES  < JDC_MIN_SYNC) ? JDC_MIN_SYNC : CLR_STAGES;
  localparam logic [COUNT-1:0] DEC_FIRST = COUNT'(1);

  jdc_pins_t         pins_raw;
  jdc_pins_t         pins_s;
  logic              clr_hold;
  logic              adv;
  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_nxt;
  logic [COUNT-1:0]  dec_nxt;
  logic              carry_nxt;
  logic [COUNT-1:0]  dec_q;
  logic              carry_q;

  assign pins_raw.pulse   = count_i;
  assign pins_raw.inhibit = inhibit_i;

  jdc_sync #(.DEPTH(SYNC_D), .WIDTH($bits(jdc_pins_t))) u_sync (
    .clk  (clk),
    .din  (pins_raw),
    .dout (pins_s)
  );

  jdc_clr_sync #(.DEPTH(CLR_D)) u_clr (
    .clk       (clk),
    .clr_async (clear_i),
    .clr_hold  (clr_hold)
  );

  jdc_advance u_adv (
    .clk  (clk),
    .pins (pins_s),
    .adv  (adv)
  );

  jdc_ring #(.STAGES(STAGES)) u_ring (
    .clk      (clk),
    .clr      (clr_hold),
    .adv      (adv),
    .ring_q   (ring_q),
    .ring_nxt (ring_nxt)
  );

  // Decode the next word so the registered outputs line up with the ring.
  jdc_decode #(.STAGES(STAGES)) u_dec (
    .ring  (ring_nxt),
    .dec   (dec_nxt),
    .carry (carry_nxt)
  );

  always_ff @(posedge clk or posedge clr_hold) begin
    if (clr_hold) begin
      dec_q   <= DEC_FIRST;
      carry_q <= 1'b1;
    end else begin
      dec_q   <= dec_nxt;
      carry_q <= carry_nxt;
    end
  end

  assign dec_o   = dec_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/johnson_decade_div_chk.sv
module johnson_decade_div_chk #(
  parameter int unsigned STAGES = 5,
  parameter int unsigned COUNT  = 10
) (
  input logic              clk,
  input logic              clear_i,
  input logic              inhibit_i,
  input logic              clr_hold,
  input logic [STAGES-1:0] ring_q,
  input logic [COUNT-1:0]  dec_o,
  input logic              carry_o
);
  logic ring_ok;
  assign ring_ok = ($countones(ring_q[STAGES-2:0] ^ ring_q[STAGES-1:1]) <= 1);

  // R2
  p_onehot_r2: assert property (@(posedge clk) disable iff (clear_i || clr_hold)
    $countones(dec_o) == 1);

  // R3: any change of the decoded word is a single step forward
  p_step_r3: assert property (@(posedge clk) disable iff (clear_i || clr_hold)
    !$stable(dec_o) |-> dec_o == {$past(dec_o[COUNT-2:0]), $past(dec_o[COUNT-1])});

  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (clear_i || clr_hold)
    (inhibit_i && $past(inhibit_i)) |=> $stable(dec_o));

  // R6: carry and the low half of the decode come from separate logic
  p_carry_r6: assert property (@(posedge clk) disable iff (clear_i || clr_hold)
    carry_o == (|dec_o[STAGES-1:0]));

  // R8
  p_clear_r8: assert property (@(posedge clk)
    clr_hold |-> (dec_o == COUNT'(1) && carry_o));

  // R11
  p_recover_r11: assert property (@(posedge clk) disable iff (clear_i || clr_hold)
    !ring_ok |=> ring_ok);
endmodule

bind johnson_decade_div johnson_decade_div_chk #(.STAGES(STAGES), .COUNT(COUNT)) u_chk (
  .clk       (clk),
  .clear_i   (clear_i),
  .inhibit_i (inhibit_i),
  .clr_hold  (clr_hold),
  .ring_q    (ring_q),
  .dec_o     (dec_o),
  .carry_o   (carry_o)
);

// File: tb/tb_johnson_decade_div.sv
`timescale 1ns/1ps
module tb_johnson_decade_div;
  localparam int COUNT = 10;
  localparam int FB_N  = 6;

  logic clk = 1'b0;
  logic count_tb = 1'b0;
  logic inhibit_tb = 1'b0;
  logic clear_tb = 1'b1;
  logic fb_en = 1'b0;
  logic clear_w;
  logic [COUNT-1:0] dec;
  logic carry;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0;

  always #10 clk = ~clk;

  assign clear_w = clear_tb | (fb_en & dec[FB_N]);

  johnson_decade_div dut (
    .clk       (clk),
    .count_i   (count_tb),
    .inhibit_i (inhibit_tb),
    .clear_i   (clear_w),
    .dec_o     (dec),
    .carry_o   (carry)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    count_tb = 1'b1; settle(4);
    count_tb = 1'b0; settle(4);
  endtask

  task automatic expect_state(input string tag);
    chk(tag, 32'(dec), 32'(COUNT'(1) << exp_cnt));
    chk(tag, 32'(carry), 32'(exp_cnt < 5));
  endtask

  task automatic do_clear();
    clear_tb = 1'b1; settle(2);
    clear_tb = 1'b0; settle(3);
    exp_cnt = 0;
  endtask

  task automatic t_reset();
    do_clear();
    expect_state("R1 state after clear");
  endtask

  task automatic t_sequence();
    for (int i = 0; i < 12; i++) begin
      pulse();
      exp_cnt = (exp_cnt + 1) % COUNT;
      chk("R3 decoded count", 32'(dec), 32'(COUNT'(1) << exp_cnt));
      chk("R6 carry", 32'(carry), 32'(exp_cnt < 5));
      chk("R2 one hot", 32'($countones(dec)), 32'd1);
    end
  endtask

  task automatic t_latency();
    count_tb = 1'b1;
    settle(2);
    expect_state("R7 unchanged after two edges");
    settle(1);
    exp_cnt = (exp_cnt + 1) % COUNT;
    expect_state("R7 changed on third edge");
    count_tb = 1'b0; settle(4);
  endtask

  task automatic t_inhibit();
    inhibit_tb = 1'b1; settle(3);
    for (int i = 0; i < 3; i++) pulse();
    expect_state("R4 pulses while inhibited");
    count_tb = 1'b1; settle(4);
    expect_state("R4 count rise while inhibited");
    inhibit_tb = 1'b0; settle(4);
    exp_cnt = (exp_cnt + 1) % COUNT;
    expect_state("R5 inhibit fall with count high");
    count_tb = 1'b0; settle(4);
    expect_state("R5 count fall");
  endtask

  task automatic t_collide();
    count_tb = 1'b1; inhibit_tb = 1'b1; settle(5);
    expect_state("R12 both rise together");
    count_tb = 1'b0; inhibit_tb = 1'b0; settle(5);
    expect_state("R12 both fall together");
    pulse();
    exp_cnt = (exp_cnt + 1) % COUNT;
    expect_state("R12 next pulse counts");
  endtask

  task automatic t_async_clear();
    for (int i = 0; i < 3; i++) begin
      pulse();
      exp_cnt = (exp_cnt + 1) % COUNT;
    end
    @(negedge clk);
    #5 clear_tb = 1'b1;
    #1;
    exp_cnt = 0;
    expect_state("R8 clear without clock edge");
    @(negedge clk);
    clear_tb = 1'b0; settle(3);
    expect_state("R8 holds after release");
    pulse();
    exp_cnt = 1;
    expect_state("R8 first count after release");
  endtask

  task automatic t_clear_edge();
    clear_tb = 1'b1; settle(2);
    count_tb = 1'b1; settle(4);
    clear_tb = 1'b0; settle(5);
    exp_cnt = 0;
    expect_state("R9 no advance at release");
    count_tb = 1'b0; settle(4);
    expect_state("R9 count fall after release");
    pulse();
    exp_cnt = 1;
    expect_state("R9 next pulse counts");
  endtask

  task automatic t_divn();
    do_clear();
    fb_en = 1'b1;
    for (int i = 0; i < 14; i++) begin
      pulse();
      exp_cnt = (exp_cnt + 1) % FB_N;
      expect_state("R10 shortened cycle");
    end
    fb_en = 1'b0;
    do_clear();
  endtask

  task automatic t_illegal();
    logic [4:0] pats [2];
    pats[0] = 5'b01010;
    pats[1] = 5'b11011;
    for (int p = 0; p < 2; p++) begin
      do_clear();
      for (int i = 0; i < 9; i++) pulse();
      exp_cnt = 9;
      expect_state("R11 at count nine");
      @(negedge clk);
      force dut.u_ring.ring_q = pats[p];
      #1 release dut.u_ring.ring_q;
      @(negedge clk);
      exp_cnt = 0;
      expect_state("R11 recovered to zero");
      pulse();
      exp_cnt = 1;
      expect_state("R11 counting resumes");
    end
  endtask

  initial begin
    settle(4);
    t_reset();
    t_sequence();
    t_latency();
    t_inhibit();
    t_collide();
    t_async_clear();
    t_clear_edge();
    t_divn();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule